// File: doc/BRIEF.md
# Delayed Steering Guard-Time Validator

This block qualifies a raw early-steering flag from a dual-tone detector. It produces a delayed steering output that a controller can trust without running its own timing algorithm.

A detected tone is accepted only after the early flag has stayed high for a programmable number of timebase ticks. Once the output is high, short gaps in the early flag are bridged. The output drops only after the flag has stayed low for a second programmable number of ticks.

Timing comes from a one-cycle clock-enable tick, nominally one per millisecond. Both guard lengths are parameters counted in ticks. With the default of 30 ticks, tones and dropouts of 20 ms or less are rejected, and tones and pauses of 40 ms or more are accepted. The early flag is asynchronous to the clock and passes through a two-flop synchronizer. A powerdown input forces the output low and discards any timing in progress.

Top module: `dstd_validator`

## Requirements
- R1: While reset is asserted and after it is released, `dstd` is 0 until a tone is qualified.
- R2: From the low state, `dstd` rises at the tick edge on which the synchronized early flag has been seen high on PRESENT_TICKS consecutive ticks. A tone seen on fewer ticks never raises it.
- R3: If the early flag drops before the presence guard completes, the presence count restarts from zero. A later tone then needs the full PRESENT_TICKS ticks.
- R4: While `dstd` is high, a dropout seen on fewer than ABSENT_TICKS ticks leaves `dstd` high.
- R5: While `dstd` is high, `dstd` falls at the tick edge on which the early flag has been seen low on ABSENT_TICKS consecutive ticks.
- R6: If the early flag returns during the absence guard, the absence count restarts. A following dropout needs the full ABSENT_TICKS ticks.
- R7: Guard counting advances only on cycles with `tick` high. Without ticks, `dstd` holds its value whatever the early flag does.
- R8: One cycle after `pwdn` is sampled high, `dstd` is 0, and it stays 0 for as long as `pwdn` remains high.
- R9: Powerdown discards a partially completed presence count. After `pwdn` returns low, a tone needs the full PRESENT_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| est_in | input | 1 | Raw early-steering flag, asynchronous |
| pwdn | input | 1 | Powerdown, synchronous, active high |
| tick | input | 1 | Timebase clock enable, one cycle wide |
| dstd | output | 1 | Delayed (guard-qualified) steering |

## Verification
The bench sweeps tone lengths and dropout lengths across each guard boundary in a small configuration:
- An off-by-one presence counter would accept a tone one tick short, or accept one tick late.
- An off-by-one absence counter would drop the output on a tolerable gap.
- A counter that is not cleared on an interruption would let two short bursts add up to an accepted tone. A counter that is not reloaded would let two short gaps add up to a release.

Long stretches without ticks catch a counter that runs on the raw clock. Powerdown pulses in the middle of qualification catch a design that keeps stale progress through powerdown.

// File: rtl/dsv_pkg.sv
package dsv_pkg;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_HELD = 1'b1
    } steer_state_e;

    typedef struct packed {
        steer_state_e state;
    } steer_regs_t;

endpackage

// File: rtl/dsv_sync2.sv
module dsv_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic [STAGES-1:0] stg;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.stg = {r_q.stg[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign q = r_q.stg[STAGES-1];
endmodule

// File: rtl/dsv_guard_timer.sv
module dsv_guard_timer #(
    parameter int LIMIT = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } timer_regs_t;

    timer_regs_t r_d, r_q;

    // a qualifying tick on the last count completes the guard
    assign done = run && tick && (r_q.cnt == LAST);

    always_comb begin
        r_d = r_q;
        if (!run)       r_d.cnt = '0;
        else if (done)  r_d.cnt = '0;
        else if (tick)  r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST);

    // R3
    clr_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (r_q.cnt == '0));

    // R7
    no_tick_hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(r_q.cnt));
endmodule

// File: rtl/dstd_validator.sv
module dstd_validator
    import dsv_pkg::*;
#(
    parameter int PRESENT_TICKS = 30,
    parameter int ABSENT_TICKS  = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic est_in,
    input  logic pwdn,
    input  logic tick,
    output logic dstd
);
    logic est_s;
    logic present_run, absent_run;
    logic present_done, absent_done;

    steer_regs_t r_d, r_q;

    dsv_sync2 #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (est_in),
        .q     (est_s)
    );

    assign present_run = est_s  && (r_q.state == ST_WAIT) && !pwdn;
    assign absent_run  = !est_s && (r_q.state == ST_HELD) && !pwdn;

    dsv_guard_timer #(.LIMIT(PRESENT_TICKS)) u_present (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (present_run),
        .tick  (tick),
        .done  (present_done)
    );

    dsv_guard_timer #(.LIMIT(ABSENT_TICKS)) u_absent (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (absent_run),
        .tick  (tick),
        .done  (absent_done)
    );

    always_comb begin
        r_d = r_q;
        if (pwdn) begin
            r_d.state = ST_WAIT;
        end else begin
            unique case (r_q.state)
                ST_WAIT: if (present_done) r_d.state = ST_HELD;
                ST_HELD: if (absent_done)  r_d.state = ST_WAIT;
                default: r_d.state = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_WAIT};
        else        r_q <= r_d;
    end

    assign dstd = (r_q.state == ST_HELD);

    // R8
    pwdn_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwdn |=> !dstd);

    // R2
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dstd) |-> ($past(tick) && $past(est_s)));

    // R5
    fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dstd) && !$past(pwdn)) |-> ($past(tick) && !$past(est_s)));

    // R7
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !pwdn) |=> $stable(dstd));
endmodule

// File: tb/tb_dstd_validator.sv
module tb_dstd_validator;
    localparam int P  = 4;
    localparam int A  = 3;
    localparam int TP = 4;

    logic clk = 1'b0;
    logic rst_n, est, pwdn, tick;
    logic dstd;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    dstd_validator #(.PRESENT_TICKS(P), .ABSENT_TICKS(A)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .est_in (est),
        .pwdn   (pwdn),
        .tick   (tick),
        .dstd   (dstd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // hold est at lvl for n tick periods; chg = first tick index where dstd changed
    task automatic hold(input logic lvl, input int n, output int chg, output logic fin);
        logic start;
        start = dstd;
        est   = lvl;
        chg   = 0;
        for (int k = 1; k <= n; k++) begin
            for (int j = 0; j < TP; j++) begin
                tick = (j == TP - 1);
                @(negedge clk);
            end
            tick = 1'b0;
            if (chg == 0 && dstd !== start) chg = k;
        end
        fin = dstd;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int   c;
        logic f;
        rst_n = 1'b0; est = 1'b0; pwdn = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        check(dstd === 1'b0, "R1 in reset", dstd, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(dstd === 1'b0, "R1 after reset", dstd, 0);

        // R2: tone length sweep across the presence guard
        for (int L = 1; L <= P + 2; L++) begin
            hold(1'b0, A + 1, c, f);
            hold(1'b1, L, c, f);
            check(c == ((L >= P) ? P : 0), $sformatf("R2 tone len %0d", L), c, (L >= P) ? P : 0);
        end

        // R4 / R5: dropout length sweep across the absence guard
        for (int D = 1; D <= A + 1; D++) begin
            hold(1'b0, A + 1, c, f);
            hold(1'b1, P + 1, c, f);
            check(f === 1'b1, "R2 accepted before dropout", f, 1);
            hold(1'b0, D, c, f);
            check(c == ((D >= A) ? A : 0), $sformatf("%s dropout %0d", (D >= A) ? "R5" : "R4", D),
                  c, (D >= A) ? A : 0);
            hold(1'b1, 2, c, f);
            check(f === ((D < A) ? 1'b1 : 1'b0), $sformatf("R4 state after dropout %0d", D),
                  f, (D < A) ? 1 : 0);
        end

        // R3: interrupted tone restarts the presence count
        hold(1'b0, A + 1, c, f);
        hold(1'b1, P - 1, c, f);
        check(f === 1'b0, "R3 short burst", f, 0);
        hold(1'b0, 1, c, f);
        hold(1'b1, P - 1, c, f);
        check(f === 1'b0, "R3 no accumulation", f, 0);
        hold(1'b1, 1, c, f);
        check(c == 1, "R3 full guard after restart", c, 1);

        // R6: returning tone reloads the absence count
        hold(1'b0, A - 1, c, f);
        check(f === 1'b1, "R6 first gap", f, 1);
        hold(1'b1, 1, c, f);
        hold(1'b0, A - 1, c, f);
        check(f === 1'b1, "R6 second gap no accumulation", f, 1);
        hold(1'b0, 1, c, f);
        check(c == 1, "R6 release after full gap", c, 1);

        // R7: no ticks, no progress
        est = 1'b1;
        repeat (12 * P) @(negedge clk);
        check(dstd === 1'b0, "R7 no rise without ticks", dstd, 0);
        hold(1'b1, P, c, f);
        check(c == P, "R7 rise counts ticks only", c, P);
        est = 1'b0;
        repeat (12 * A) @(negedge clk);
        check(dstd === 1'b1, "R7 no fall without ticks", dstd, 1);

        // R8: powerdown forces low
        hold(1'b1, 1, c, f);
        pwdn = 1'b1;
        @(negedge clk);
        check(dstd === 1'b0, "R8 low one cycle after pwdn", dstd, 0);
        hold(1'b1, P + 2, c, f);
        check(c == 0 && f === 1'b0, "R8 stays low in pwdn", f, 0);

        // R9: powerdown discards partial presence count
        pwdn = 1'b0;
        hold(1'b1, P - 1, c, f);
        check(f === 1'b0, "R9 partial before pwdn", f, 0);
        pwdn = 1'b1;
        @(negedge clk);
        pwdn = 1'b0;
        hold(1'b1, P - 1, c, f);
        check(f === 1'b0, "R9 count cleared by pwdn", f, 0);
        hold(1'b1, 1, c, f);
        check(c == 1, "R9 full guard after pwdn", c, 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule